// File: doc/BRIEF.md
# General Purpose I/O Port Register

This block is one 8-bit I/O port as a processor core sees it through a register. The core writes a whole byte into an output latch, or sets or clears a single latch bit chosen by a 3-bit index. The latch drives the pad control outputs. Each bit's output-mode input picks between push-pull and open-drain behaviour. In open-drain mode a logic-high latch bit releases the pin.

Reads come in two kinds, each with its own strobe. An ordinary read returns the pin levels after a two-flop synchronizer, and it does so whatever peripheral is routed to the pin. Bits flagged as analog inputs read as zero on this path. A read that belongs to a read-modify-write sequence returns the latch instead, so the core can change some bits without copying the pin levels into the others. The result is then written back with the normal byte write.

Top module: `gpio_port`

## Requirements
- R1: After reset every latch bit is 1. pad_out is 8'hFF, and a read-modify-write read returns 8'hFF.
- R2: When wr_en is high at a clock edge, the latch takes wr_data at that edge. With no write, set or clear, the latch keeps its value.
- R3: bit_set (or bit_clr) with index bit_idx (0 = LSB) makes that latch bit 1 (or 0) at the clock edge and leaves every other bit unchanged.
- R4: If several updates arrive in one cycle, wr_en wins over bit_clr, and bit_clr wins over bit_set.
- R5: An ordinary read (rd_en high, rmw_rd_en low) returns pin_in as sampled two clock edges earlier, regardless of the latch.
- R6: While rmw_rd_en is high, rd_data equals the latch contents, ignoring pins and analog flags. rmw_rd_en has priority over rd_en.
- R7: On an ordinary read, every bit whose analog_in bit is 1 reads as 0.
- R8: A latch bit of 0 gives pad_out 0 and pad_oe 1 for that bit, whatever its mode.
- R9: A latch bit of 1 gives pad_out 1. pad_oe is 1 when mode_pp for that bit is 1 (push-pull) and 0 when it is 0 (open-drain, pin released).
- R10: With neither read strobe high, rd_data is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte write value |
| bit_set | input | 1 | Single-bit set strobe |
| bit_clr | input | 1 | Single-bit clear strobe |
| bit_idx | input | 3 | Bit index for set/clear |
| rd_en | input | 1 | Ordinary read strobe (pin levels) |
| rmw_rd_en | input | 1 | Read-modify-write read strobe (latch) |
| rd_data | output | 8 | Read data |
| mode_pp | input | 8 | Per-bit output mode, 1 = push-pull, 0 = open-drain |
| analog_in | input | 8 | Per-bit analog flag, 1 = reads as zero |
| pin_in | input | 8 | Pin input levels (asynchronous) |
| pad_out | output | 8 | Output level to pad |
| pad_oe | output | 8 | Output driver enable to pad |

## Verification
The bench drives a pin pattern that differs from the latch and then issues both kinds of read. A design that returns the latch on an ordinary read, or the pins on a read-modify-write read, shows the wrong byte. Pin changes are checked on the exact cycle they appear, so a synchronizer with one stage too few or too many shows up as data one cycle early or late. Colliding write, set and clear strobes expose a wrong priority order. Set and clear at index 0 and index 7 catch an off-by-one in the bit index. An open-drain high with push-pull toggled separates a driver that never releases the pin from one that releases a low.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int PORT_W = 8;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_BYTE  = 2'd1,
        OP_CLEAR = 2'd2,
        OP_SET   = 2'd3
    } latch_op_e;

    // byte write beats clear, clear beats set
    function automatic latch_op_e decode_op(input logic wr, input logic clr, input logic set);
        if (wr)       return OP_BYTE;
        else if (clr) return OP_CLEAR;
        else if (set) return OP_SET;
        else          return OP_HOLD;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stage;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            st_d.stage[s] = st_q.stage[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.stage[STAGES-1];

    // R5
    stage_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> st_q.stage[0] == $past(async_in));

endmodule

// File: rtl/gpio_latch.sv
module gpio_latch
    import gpio_port_pkg::*;
#(
    parameter int              WIDTH     = 8,
    parameter logic [WIDTH-1:0] RESET_VAL = '1,
    localparam int             IDX_W     = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             bit_set,
    input  logic             bit_clr,
    input  logic [IDX_W-1:0] bit_idx,
    output logic [WIDTH-1:0] latch_q
);

    typedef struct packed {
        logic [WIDTH-1:0] val;
    } latch_state_t;

    latch_state_t st_d, st_q;
    latch_op_e    op;
    logic [WIDTH-1:0] sel_mask;

    always_comb begin
        op       = decode_op(wr_en, bit_clr, bit_set);
        sel_mask = WIDTH'(1) << bit_idx;
        st_d     = st_q;
        unique case (op)
            OP_BYTE:  st_d.val = wr_data;
            OP_CLEAR: st_d.val = st_q.val & ~sel_mask;
            OP_SET:   st_d.val = st_q.val |  sel_mask;
            default:  st_d.val = st_q.val;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{val: RESET_VAL};
        else        st_q <= st_d;
    end

    assign latch_q = st_q.val;

    // R2
    byte_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> latch_q == $past(wr_data));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !bit_set && !bit_clr) |=> $stable(latch_q));

    // R3
    set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_set && !bit_clr && !wr_en) |=> latch_q[$past(bit_idx)] == 1'b1);

    // R4
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_clr && !wr_en) |=> latch_q[$past(bit_idx)] == 1'b0);

    // R3
    one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bit_set || bit_clr) && !wr_en) |=> $countones(latch_q ^ $past(latch_q)) <= 1);

endmodule

// File: rtl/gpio_drive.sv
module gpio_drive #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] mode_pp,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_comb begin
            pad_out[b] = latch_q[b];
            // low always driven; high driven only in push-pull
            pad_oe[b]  = !latch_q[b] || mode_pp[b];
        end
    end

endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             rmw_rd_en,
    input  logic [WIDTH-1:0] pin_sync,
    input  logic [WIDTH-1:0] analog_in,
    input  logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] pin_view;

    always_comb begin
        pin_view = pin_sync & ~analog_in;
        if (rmw_rd_en)  rd_data = latch_q;
        else if (rd_en) rd_data = pin_view;
        else            rd_data = '0;
    end

    // R7
    analog_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rmw_rd_en) |-> (rd_data & analog_in) == '0);

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !rmw_rd_en) |-> rd_data == '0);

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int               WIDTH       = PORT_W,
    parameter int               SYNC_STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL   = '1,
    localparam int              IDX_W       = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             bit_set,
    input  logic             bit_clr,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             rd_en,
    input  logic             rmw_rd_en,
    output logic [WIDTH-1:0] rd_data,
    input  logic [WIDTH-1:0] mode_pp,
    input  logic [WIDTH-1:0] analog_in,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);

    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] pin_sync;

    gpio_latch #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL)) u_latch (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(wr_data),
        .bit_set(bit_set), .bit_clr(bit_clr), .bit_idx(bit_idx),
        .latch_q(latch_q)
    );

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
    );

    gpio_drive #(.WIDTH(WIDTH)) u_drive (
        .latch_q(latch_q), .mode_pp(mode_pp), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    gpio_rdmux #(.WIDTH(WIDTH)) u_rdmux (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rmw_rd_en(rmw_rd_en),
        .pin_sync(pin_sync), .analog_in(analog_in), .latch_q(latch_q),
        .rd_data(rd_data)
    );

    // R6
    rmw_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rmw_rd_en |-> rd_data == pad_out);

    // R8
    low_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~latch_q & ~pad_oe) == '0) && ((~latch_q & pad_out) == '0));

    // R9
    od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q & ~mode_pp & pad_oe) == '0);

    // R9
    pp_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q & mode_pp & ~(pad_oe & pad_out)) == '0);

endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 0, bit_set = 0, bit_clr = 0, rd_en = 0, rmw_rd_en = 0;
    logic [7:0] wr_data = 0, mode_pp = 0, analog_in = 0, pin_in = 0;
    logic [2:0] bit_idx = 0;
    logic [7:0] rd_data, pad_out, pad_oe;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // reference state
    logic [7:0] m_lat = 8'hFF;
    logic [7:0] m_q[$] = '{8'h00, 8'h00};

    always #10 clk = ~clk;

    gpio_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .bit_set(bit_set), .bit_clr(bit_clr), .bit_idx(bit_idx),
        .rd_en(rd_en), .rmw_rd_en(rmw_rd_en), .rd_data(rd_data),
        .mode_pp(mode_pp), .analog_in(analog_in), .pin_in(pin_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lat = 8'hFF;
            m_q = '{8'h00, 8'h00};
        end else begin
            m_q.push_back(pin_in);
            void'(m_q.pop_front());
            if (wr_en)        m_lat = wr_data;
            else if (bit_clr) m_lat[bit_idx] = 1'b0;
            else if (bit_set) m_lat[bit_idx] = 1'b1;
        end
    end

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [7:0] e_rd, e_oe;
        if (rmw_rd_en)  e_rd = m_lat;
        else if (rd_en) e_rd = m_q[0] & ~analog_in;
        else            e_rd = 8'h00;
        for (int b = 0; b < 8; b++) e_oe[b] = !m_lat[b] || mode_pp[b];
        chk(tag, "rd_data", rd_data, e_rd);
        chk("R8 R9", "pad_out", pad_out, m_lat);
        chk("R8 R9", "pad_oe", pad_oe, e_oe);
    endtask

    task automatic cyc();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        wr_en = 0; bit_set = 0; bit_clr = 0; rd_en = 0; rmw_rd_en = 0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state via latch read and pads
        tag = "R1"; rmw_rd_en = 1; cyc();
        chk("R1", "reset latch", rd_data, 8'hFF);
        chk("R1", "reset pad_out", pad_out, 8'hFF);
        // R10: no strobes
        idle(); tag = "R10"; pin_in = 8'h5A; cyc(); cyc(); cyc();
        // R2: byte writes, held value
        tag = "R2";
        foreach (wr_data[i]) ;
        wr_en = 1; wr_data = 8'hA5; cyc();
        wr_en = 0; rmw_rd_en = 1; cyc(); cyc();
        chk("R2", "held A5", rd_data, 8'hA5);
        wr_en = 1; wr_data = 8'h3C; cyc(); wr_en = 0; cyc();
        // R3: set and clear each index
        tag = "R3"; wr_en = 1; wr_data = 8'h00; cyc(); wr_en = 0;
        for (int i = 0; i < 8; i++) begin
            bit_set = 1; bit_idx = 3'(i); cyc();
        end
        bit_set = 0; cyc();
        chk("R3", "all set", rd_data, 8'hFF);
        bit_clr = 1; bit_idx = 3'd7; cyc(); bit_idx = 3'd0; cyc(); bit_clr = 0; cyc();
        chk("R3", "clear 7 and 0", rd_data, 8'h7E);
        // R4: collisions
        tag = "R4";
        wr_en = 1; bit_set = 1; bit_idx = 3'd2; wr_data = 8'h10; cyc();
        wr_en = 0; bit_set = 0; cyc();
        chk("R4", "write over set", rd_data, 8'h10);
        bit_set = 1; bit_clr = 1; bit_idx = 3'd4; cyc();
        bit_set = 0; bit_clr = 0; cyc();
        chk("R4", "clear over set", rd_data, 8'h00);
        // R5: ordinary read sees pins two edges late
        tag = "R5"; rmw_rd_en = 0; rd_en = 1; analog_in = 8'h00;
        wr_en = 1; wr_data = 8'h0F; cyc(); wr_en = 0;
        pin_in = 8'hC3; cyc(); cyc(); cyc();
        chk("R5", "pins not latch", rd_data, 8'hC3);
        pin_in = 8'h81; cyc();
        chk("R5", "one edge still old", rd_data, 8'hC3);
        cyc();
        chk("R5", "two edges new", rd_data, 8'h81);
        // R7: analog masking
        tag = "R7"; pin_in = 8'hFF; analog_in = 8'hF0; cyc(); cyc(); cyc();
        chk("R7", "analog bits zero", rd_data, 8'h0F);
        // R6: rmw read returns latch despite pins/analog, priority over rd_en
        tag = "R6"; rmw_rd_en = 1; cyc();
        chk("R6", "rmw latch", rd_data, 8'h0F);
        // RMW sequence: read latch, modify, write back
        wr_data = rd_data ^ 8'hFF; wr_en = 1; cyc(); wr_en = 0; cyc();
        chk("R6", "rmw write back", rd_data, 8'hF0);
        // R8 R9: drive modes
        tag = "R6"; wr_en = 1; wr_data = 8'hAA; mode_pp = 8'h00; cyc(); wr_en = 0; cyc();
        chk("R9", "open-drain release", pad_oe, 8'h55);
        mode_pp = 8'hFF; cyc();
        chk("R9", "push-pull drive", pad_oe, 8'hFF);
        mode_pp = 8'h0F; cyc();
        chk("R8", "low driven", pad_oe & ~pad_out, 8'h55);
        // random mixed traffic
        idle();
        for (int n = 0; n < 2000; n++) begin
            wr_en = ($urandom % 5) == 0; wr_data = 8'($urandom);
            bit_set = ($urandom % 3) == 0; bit_clr = ($urandom % 3) == 0;
            bit_idx = 3'($urandom); rd_en = $urandom % 2; rmw_rd_en = ($urandom % 3) == 0;
            mode_pp = 8'($urandom); analog_in = 8'($urandom & $urandom);
            pin_in = 8'($urandom);
            tag = rmw_rd_en ? "R6" : (rd_en ? "R5 R7" : "R10");
            cyc();
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule